// File: doc/BRIEF.md
# Multi-Line Display RAM Scan Addresser

This block turns a scan position on a character display (a line index and a character column) into the display RAM address to fetch. It supports three layouts. In one-line mode, a single line covers 80 consecutive addresses starting at 00h. In two-line mode, two lines of 40 characters start at 00h and 40h. In four-line mode, four lines of 20 characters start at 00h, 20h, 40h and 60h. The address windows of the lines are therefore not contiguous. The block also reports whether the common drive runs at 1/17 or 1/33 duty.

The whole display can be scrolled one position left or right. One shared offset is added to the column, modulo the active line length, so each line wraps inside its own address window. The layout is held in a three-state machine. The states are ST_ONE, ST_TWO and ST_FOUR, and reset enters ST_ONE. On every clock the machine moves to the state that the line-mode input selects. Any transition between two different states, and any return-home command, zeroes the scroll offset. The address output is registered one clock after the scan position.

Top module: `lcd_scan_addr`

## Requirements
- R1: The line_mode input selects the layout. 2'b00 selects one line, 2'b01 selects two lines, and 2'b10 or 2'b11 selects four lines. The new layout takes effect at the next clock. duty_33 is 0 in the one-line layout (1/17 duty) and 1 in the other two (1/33 duty).
- R2: In the one-line layout, line_idx is ignored and the address is (col + offset) mod 80.
- R3: In the two-line layout, line_idx[0] selects the line. The base is 00h for line 0 and 40h for line 1. The address is base + (col + offset) mod 40, so line 1 ends at 67h.
- R4: In the four-line layout, the base is line_idx × 20h. The address is base + (col + offset) mod 20, so line 3 ends at 73h.
- R5: A shift_left pulse adds 1 to the offset, modulo the line length. Afterwards, column 0 shows the address that column 1 showed before.
- R6: A shift_right pulse subtracts 1 from the offset, modulo the line length. From offset 0, column 0 then shows the last address of its line.
- R7: If shift_left and shift_right are both high in the same cycle, the offset does not change.
- R8: home zeroes the offset and takes priority over the shift inputs.
- R9: A change of layout zeroes the offset, and any shift requested in that cycle is ignored.
- R10: A column at or beyond the active line length yields the line's base address.
- R11: addr reflects the inputs sampled at the previous clock edge. Reset gives addr 0, offset 0 and the one-line layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_mode | input | 2 | Layout select (R1 encoding) |
| shift_left | input | 1 | Scroll one position left |
| shift_right | input | 1 | Scroll one position right |
| home | input | 1 | Clear scroll offset |
| line_idx | input | 2 | Scanned line index |
| col | input | 7 | Scanned character column |
| addr | output | 7 | Registered display RAM address |
| duty_33 | output | 1 | 1 = 1/33 duty, 0 = 1/17 duty |

## Verification
The bench builds the block with its default parameters: line lengths of 80, 40 and 20, strides of 64 and 32, and a 7-bit address. With these values the top addresses 4Fh, 67h and 73h and every wrap point are reachable, and so are columns past the line end, since the random column range goes to 85. The random phase rarely changes the layout, so the offset has time to travel across a whole line and wrap in both directions before a layout change clears it.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        ST_ONE  = 2'd0,
        ST_TWO  = 2'd1,
        ST_FOUR = 2'd2
    } line_state_e;

endpackage

// File: rtl/lcd_scan_mode_fsm.sv
module lcd_scan_mode_fsm
    import lcd_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  line_mode,
    output line_state_e state_q,
    output logic        mode_chg,
    output logic        duty_33
);

    line_state_e state_d;

    always_comb begin
        unique case (line_mode)
            2'b00:   state_d = ST_ONE;
            2'b01:   state_d = ST_TWO;
            2'b10:   state_d = ST_FOUR;
            2'b11:   state_d = ST_FOUR;
            default: state_d = ST_ONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ONE;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_chg = (state_d != state_q);
        unique case (state_q)
            ST_ONE:  duty_33 = 1'b0;
            ST_TWO:  duty_33 = 1'b1;
            ST_FOUR: duty_33 = 1'b1;
            default: duty_33 = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcd_scan_offset.sv
module lcd_scan_offset
    import lcd_scan_pkg::*;
#(
    parameter int AW     = 7,
    parameter int LEN_1L = 80,
    parameter int LEN_2L = 40,
    parameter int LEN_4L = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_state_e   state_q,
    input  logic          mode_chg,
    input  logic          home,
    input  logic          shift_left,
    input  logic          shift_right,
    output logic [AW-1:0] off_q
);

    logic [AW-1:0] len_m1;
    logic [AW-1:0] off_d;

    always_comb begin
        unique case (state_q)
            ST_ONE:  len_m1 = AW'(LEN_1L - 1);
            ST_TWO:  len_m1 = AW'(LEN_2L - 1);
            ST_FOUR: len_m1 = AW'(LEN_4L - 1);
            default: len_m1 = AW'(LEN_1L - 1);
        endcase
    end

    always_comb begin
        off_d = off_q;
        if (mode_chg || home) begin
            off_d = '0;
        end else if (shift_left && !shift_right) begin
            off_d = (off_q == len_m1) ? '0 : off_q + AW'(1);
        end else if (shift_right && !shift_left) begin
            off_d = (off_q == '0) ? len_m1 : off_q - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

endmodule

// File: rtl/lcd_scan_map.sv
module lcd_scan_map
    import lcd_scan_pkg::*;
#(
    parameter int AW        = 7,
    parameter int LEN_1L    = 80,
    parameter int LEN_2L    = 40,
    parameter int LEN_4L    = 20,
    parameter int STRIDE_2L = 64,
    parameter int STRIDE_4L = 32
) (
    input  line_state_e   state_q,
    input  logic [AW-1:0] off,
    input  logic [1:0]    line_idx,
    input  logic [AW-1:0] col,
    output logic [AW-1:0] addr_d
);

    logic [AW-1:0] len;
    logic [AW-1:0] base;
    logic [AW:0]   sum;
    logic [AW:0]   pos;

    always_comb begin
        unique case (state_q)
            ST_ONE: begin
                len  = AW'(LEN_1L);
                base = '0;
            end
            ST_TWO: begin
                len  = AW'(LEN_2L);
                base = line_idx[0] ? AW'(STRIDE_2L) : '0;
            end
            ST_FOUR: begin
                len  = AW'(LEN_4L);
                base = AW'(STRIDE_4L) * AW'(line_idx);
            end
            default: begin
                len  = AW'(LEN_1L);
                base = '0;
            end
        endcase
    end

    always_comb begin
        sum = {1'b0, col} + {1'b0, off};
        pos = (sum >= {1'b0, len}) ? sum - {1'b0, len} : sum;
        if (col >= len) addr_d = base;
        else            addr_d = base + pos[AW-1:0];
    end

endmodule

// File: rtl/lcd_scan_addr.sv
module lcd_scan_addr
    import lcd_scan_pkg::*;
#(
    parameter int AW        = 7,
    parameter int LEN_1L    = 80,
    parameter int LEN_2L    = 40,
    parameter int LEN_4L    = 20,
    parameter int STRIDE_2L = 64,
    parameter int STRIDE_4L = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    line_mode,
    input  logic          shift_left,
    input  logic          shift_right,
    input  logic          home,
    input  logic [1:0]    line_idx,
    input  logic [AW-1:0] col,
    output logic [AW-1:0] addr,
    output logic          duty_33
);

    line_state_e   state_q;
    logic          mode_chg;
    logic [AW-1:0] off_q;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] addr_q;

    lcd_scan_mode_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_mode(line_mode),
        .state_q  (state_q),
        .mode_chg (mode_chg),
        .duty_33  (duty_33)
    );

    lcd_scan_offset #(
        .AW(AW), .LEN_1L(LEN_1L), .LEN_2L(LEN_2L), .LEN_4L(LEN_4L)
    ) offset_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .mode_chg   (mode_chg),
        .home       (home),
        .shift_left (shift_left),
        .shift_right(shift_right),
        .off_q      (off_q)
    );

    lcd_scan_map #(
        .AW(AW), .LEN_1L(LEN_1L), .LEN_2L(LEN_2L), .LEN_4L(LEN_4L),
        .STRIDE_2L(STRIDE_2L), .STRIDE_4L(STRIDE_4L)
    ) map_i (
        .state_q (state_q),
        .off     (off_q),
        .line_idx(line_idx),
        .col     (col),
        .addr_d  (addr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/lcd_scan_addr_chk.sv
module lcd_scan_addr_chk
    import lcd_scan_pkg::*;
#(
    parameter int AW     = 7,
    parameter int LEN_1L = 80,
    parameter int LEN_2L = 40,
    parameter int LEN_4L = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    line_mode,
    input logic          shift_left,
    input logic          shift_right,
    input logic          home,
    input logic [1:0]    line_idx,
    input logic [AW-1:0] addr,
    input logic          duty_33,
    input line_state_e   state_q,
    input logic [AW-1:0] off_q
);

    a_r1_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode == 2'b00) |=> !duty_33);

    a_r1_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode != 2'b00) |=> duty_33);

    a_r2_one_line_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONE && line_mode == 2'b00) |=> (addr < AW'(LEN_1L)));

    a_r3_two_line_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWO && line_mode == 2'b01)
            |=> (addr[AW-2:0] < (AW-1)'(LEN_2L) && addr[AW-1] == $past(line_idx[0])));

    a_r4_four_line_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOUR && line_mode[1])
            |=> (addr[4:0] < 5'(LEN_4L) && addr[AW-1:5] == $past(line_idx)));

    a_r5_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        off_q < AW'(LEN_1L));

    a_r7_both_shifts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_left && shift_right && !home)
            |=> (state_q != $past(state_q) || off_q == $past(off_q)));

    a_r8_home_clears: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> (off_q == '0));

    a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> (off_q == '0));

endmodule

bind lcd_scan_addr lcd_scan_addr_chk #(
    .AW(AW), .LEN_1L(LEN_1L), .LEN_2L(LEN_2L), .LEN_4L(LEN_4L)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_mode  (line_mode),
    .shift_left (shift_left),
    .shift_right(shift_right),
    .home       (home),
    .line_idx   (line_idx),
    .addr       (addr),
    .duty_33    (duty_33),
    .state_q    (state_q),
    .off_q      (off_q)
);

// File: tb/lcd_scan_addr_tb_top.sv
module lcd_scan_addr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_mode = 2'b00;
    logic       shift_left = 1'b0;
    logic       shift_right = 1'b0;
    logic       home = 1'b0;
    logic [1:0] line_idx = 2'b00;
    logic [6:0] col = 7'd0;
    logic [6:0] addr;
    logic       duty_33;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_state = 0;
    int m_off   = 0;

    always #5 clk = ~clk;

    lcd_scan_addr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_mode  (line_mode),
        .shift_left (shift_left),
        .shift_right(shift_right),
        .home       (home),
        .line_idx   (line_idx),
        .col        (col),
        .addr       (addr),
        .duty_33    (duty_33)
    );

    function automatic int f_state(input logic [1:0] m);
        if (m == 2'b00) return 0;
        if (m == 2'b01) return 1;
        return 2;
    endfunction

    function automatic int f_len(input int st);
        if (st == 0) return 80;
        if (st == 1) return 40;
        return 20;
    endfunction

    function automatic int f_base(input int st, input int li);
        if (st == 0) return 0;
        if (st == 1) return (li % 2) * 64;
        return li * 32;
    endfunction

    function automatic int f_addr(input int st, input int off, input int li, input int c);
        int len = f_len(st);
        if (c >= len) return f_base(st, li);
        return f_base(st, li) + (c + off) % len;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [1:0] m, input logic sl,
                        input logic sr, input logic hm, input logic [1:0] li,
                        input int c);
        int exp_a;
        int ns;
        line_mode = m; shift_left = sl; shift_right = sr; home = hm;
        line_idx = li; col = 7'(c);
        exp_a = f_addr(m_state, m_off, li, c);
        ns = f_state(m);
        if (ns != m_state) begin
            m_state = ns; m_off = 0;
        end else if (hm) begin
            m_off = 0;
        end else if (sl && !sr) begin
            m_off = (m_off + 1) % f_len(m_state);
        end else if (sr && !sl) begin
            m_off = (m_off + f_len(m_state) - 1) % f_len(m_state);
        end
        @(posedge clk);
        @(negedge clk);
        check(req, int'(addr), exp_a);
        check("R1", int'(duty_33), (m_state != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R11", int'(addr), 0);
        check("R1", int'(duty_33), 0);
        rst_n = 1'b1;

        // R2: one-line mapping ignores the line index
        step("R2", 2'b00, 0, 0, 0, 2'd3, 5);
        step("R2", 2'b00, 0, 0, 0, 2'd1, 79);
        // R5: shift left, column 0 shows former column 1
        step("R5", 2'b00, 1, 0, 0, 2'd0, 0);
        step("R5", 2'b00, 0, 0, 0, 2'd0, 0);
        step("R5", 2'b00, 0, 0, 0, 2'd0, 79);
        // R6: right twice from offset 1 -> last address at column 0
        step("R6", 2'b00, 0, 1, 0, 2'd0, 0);
        step("R6", 2'b00, 0, 1, 0, 2'd0, 0);
        step("R6", 2'b00, 0, 0, 0, 2'd0, 0);
        // R7: both shifts together hold the offset
        step("R7", 2'b00, 1, 1, 0, 2'd0, 0);
        step("R7", 2'b00, 0, 0, 0, 2'd0, 0);
        // R8: home wins over a shift
        step("R8", 2'b00, 1, 0, 1, 2'd0, 0);
        step("R8", 2'b00, 0, 0, 0, 2'd0, 0);
        // R9: layout change with shift requested clears offset
        step("R9", 2'b00, 1, 0, 0, 2'd0, 0);
        step("R9", 2'b01, 1, 0, 0, 2'd0, 0);
        step("R9", 2'b01, 0, 0, 0, 2'd1, 0);
        // R3: two-line end of line 1
        step("R3", 2'b01, 0, 0, 0, 2'd1, 39);
        // R10: beyond the line length
        step("R10", 2'b01, 0, 0, 0, 2'd1, 40);
        // R4: four-line mapping and wrap
        step("R4", 2'b11, 0, 0, 0, 2'd3, 19);
        step("R4", 2'b10, 0, 0, 0, 2'd3, 19);
        step("R6", 2'b10, 0, 1, 0, 2'd2, 0);
        step("R6", 2'b10, 0, 0, 0, 2'd2, 0);
        step("R10", 2'b10, 0, 0, 0, 2'd2, 20);

        // R11: random scan with registered output checks
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] m;
            m = ($urandom_range(0, 49) == 0) ? 2'($urandom_range(0, 3)) : line_mode;
            step((m_state == 0) ? "R2" : (m_state == 1) ? "R3" : "R4", m,
                 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 39) == 0), 2'($urandom_range(0, 3)),
                 int'($urandom_range(0, 85)));
        end

        shift_left = 1'b0; shift_right = 1'b0; home = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule